// File: doc/BRIEF.md
# Queue Interrupt Cause Router

This block sits between a set of transmit/receive queues and the interrupt vector logic. Each queue can raise a one-cycle event. The block drops the event unless that queue's cause enable and the global interrupt enable are both set. Otherwise it emits an interrupt request that carries the queue's vector number and throttle selector. When a queue targets vector 0, the block also records the event in a sticky cause register: a general event flag, plus a per-queue flag whose position comes from the queue's slot field. The block does not generate vector messages and has no throttle timers.

A transmit-timestamp capture pulse always sets a sticky timestamp status flag. When the timestamp interrupt enable and the cause-register timesync enable are both set, the capture also raises a request on vector 0 with throttle selector 0 and marks the general event and timesync cause flags. Requests from several sources in the same cycle are served one per cycle in fixed priority. Queue 0 comes first, higher queues follow, and the timestamp source is served last. Sources that have not been served stay pending. Software clears sticky flags by writing ones to the clear inputs.

Top module: `irq_cause_router`

## Requirements
- R1: After synchronous reset, `irq_valid`, `cause_q` and `ts_status` are all zero.
- R2: A queue event is dropped unless both its `q_cause_en` bit and `glb_int_en` are 1 in the event cycle. A dropped event issues no request and changes no cause bit.
- R3: An accepted event with no competing source produces `irq_valid`=1 on the clock edge that ends the event cycle. It carries that queue's `q_vec` field (queue i at bits i*VEC_W) and its `q_itr` field (bits i*ITR_W).
- R4: When a served queue's vector is 0, `cause_q` bit 0 (general event) and bit 2+slot are set. The slot is the queue's `q_slot` field at bits i*SLOT_W. A nonzero vector changes no cause bit.
- R5: Simultaneous requests are served one per cycle, lowest queue index first. Unserved requests remain pending, and no request is issued when nothing is pending or arriving.
- R6: A `ts_capture` pulse sets `ts_status` on the next edge, whatever the enables are.
- R7: A `ts_capture` raises a request only if `ts_int_en` and `ts_cause_en` are both 1. That request has vector 0 and throttle 0, sets `cause_q` bits 0 and 1, and is served after all pending queue requests.
- R8: A 1 in `cause_clr` clears the matching `cause_q` bit, and `ts_stat_clr` clears `ts_status`. A set in the same cycle takes precedence over the clear.
- R9: A new event from a queue whose earlier request is still pending merges with it, giving a single request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_int_en | input | 1 | Global interrupt enable |
| q_event | input | NQ | Per-queue event pulse |
| q_cause_en | input | NQ | Per-queue cause enable |
| q_vec | input | NQ*VEC_W | Per-queue vector index fields |
| q_slot | input | NQ*SLOT_W | Per-queue vector-0 slot fields |
| q_itr | input | NQ*ITR_W | Per-queue throttle selector fields |
| ts_capture | input | 1 | Transmit-timestamp capture pulse |
| ts_int_en | input | 1 | Timestamp interrupt enable |
| ts_cause_en | input | 1 | Timesync cause enable |
| cause_clr | input | CAUSE_W | Write-one-to-clear mask for cause_q |
| ts_stat_clr | input | 1 | Clear for ts_status |
| irq_valid | output | 1 | Interrupt request strobe |
| irq_vec | output | VEC_W | Vector index of the request |
| irq_itr | output | ITR_W | Throttle selector of the request |
| cause_q | output | CAUSE_W | Sticky cause flags: bit 0 event, bit 1 timesync, bits 2.. queue slots |
| ts_status | output | 1 | Sticky timestamp-captured flag |

## Verification
Two functions can fall in the same cycle. A queue event and an enabled timestamp capture can arrive together, and a sticky set can coincide with a software clear of the same bit. The bench fires a queue event together with an enabled timestamp capture. It expects the queue's request first and the vector-0, throttle-0 timestamp request on the following edge, with the cause register holding the union of both sets. It also drives a clear mask in the event cycle of a vector-0 queue event and expects the freshly set bits to survive.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int CAUSE_EVT_BIT = 0;
  localparam int CAUSE_TS_BIT  = 1;
  localparam int CAUSE_Q_BASE  = 2;
endpackage

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int N  = 5,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);
  // lowest index wins: scan downward so the last hit is the lowest
  always_comb begin
    gnt = '0;
    idx = '0;
    any = 1'b0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[k]) begin
        gnt    = '0;
        gnt[k] = 1'b1;
        idx    = IW'(k);
        any    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_sticky_reg.sv
module irq_sticky_reg #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~clr) | set;
  end
endmodule

// File: rtl/irq_cause_router.sv
module irq_cause_router
  import irq_router_pkg::*;
#(
  parameter int NQ      = 4,
  parameter int VEC_W   = 4,
  parameter int SLOT_W  = 2,
  parameter int ITR_W   = 2,
  parameter int CAUSE_W = CAUSE_Q_BASE + (1 << SLOT_W)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 glb_int_en,
  input  logic [NQ-1:0]        q_event,
  input  logic [NQ-1:0]        q_cause_en,
  input  logic [NQ*VEC_W-1:0]  q_vec,
  input  logic [NQ*SLOT_W-1:0] q_slot,
  input  logic [NQ*ITR_W-1:0]  q_itr,
  input  logic                 ts_capture,
  input  logic                 ts_int_en,
  input  logic                 ts_cause_en,
  input  logic [CAUSE_W-1:0]   cause_clr,
  input  logic                 ts_stat_clr,
  output logic                 irq_valid,
  output logic [VEC_W-1:0]     irq_vec,
  output logic [ITR_W-1:0]     irq_itr,
  output logic [CAUSE_W-1:0]   cause_q,
  output logic                 ts_status
);
  localparam int NR   = NQ + 1;
  localparam int IW   = $clog2(NR);
  localparam int TS_IX = NQ;

  logic [NQ-1:0]      ev_ok;
  logic               ts_ok;
  logic [NR-1:0]      req, gnt, pend_q;
  logic [IW-1:0]      gnt_idx;
  logic               gnt_any, gnt_ts;
  logic [VEC_W-1:0]   sel_vec;
  logic [SLOT_W-1:0]  sel_slot;
  logic [ITR_W-1:0]   sel_itr;
  logic [CAUSE_W-1:0] cause_set;

  // per-queue double-enable gate
  for (genvar g = 0; g < NQ; g++) begin : g_gate
    assign ev_ok[g] = q_event[g] & q_cause_en[g] & glb_int_en;
  end
  assign ts_ok = ts_capture & ts_int_en & ts_cause_en;

  // arriving requests merge with held ones
  assign req = pend_q | {ts_ok, ev_ok};

  irq_prio_arb #(.N(NR), .IW(IW)) u_arb (
    .req (req),
    .gnt (gnt),
    .idx (gnt_idx),
    .any (gnt_any)
  );

  assign gnt_ts = gnt[TS_IX];

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= req & ~gnt;
  end

  // fields of the granted source and the cause bits it sets
  always_comb begin
    sel_vec   = '0;
    sel_slot  = '0;
    sel_itr   = '0;
    cause_set = '0;
    if (gnt_any) begin
      if (gnt_ts) begin
        cause_set[CAUSE_EVT_BIT] = 1'b1;
        cause_set[CAUSE_TS_BIT]  = 1'b1;
      end else begin
        sel_vec  = q_vec[gnt_idx*VEC_W +: VEC_W];
        sel_slot = q_slot[gnt_idx*SLOT_W +: SLOT_W];
        sel_itr  = q_itr[gnt_idx*ITR_W +: ITR_W];
        if (sel_vec == '0) begin
          cause_set[CAUSE_EVT_BIT]                 = 1'b1;
          cause_set[CAUSE_Q_BASE + int'(sel_slot)] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_valid <= 1'b0;
      irq_vec   <= '0;
      irq_itr   <= '0;
    end else begin
      irq_valid <= gnt_any;
      irq_vec   <= sel_vec;
      irq_itr   <= sel_itr;
    end
  end

  irq_sticky_reg #(.W(CAUSE_W)) u_cause (
    .clk (clk),
    .rst (rst),
    .set (cause_set),
    .clr (cause_clr),
    .q   (cause_q)
  );

  irq_sticky_reg #(.W(1)) u_tsstat (
    .clk (clk),
    .rst (rst),
    .set (ts_capture),
    .clr (ts_stat_clr),
    .q   (ts_status)
  );
endmodule

// File: rtl/irq_cause_router_chk.sv
module irq_cause_router_chk #(
  parameter int NQ      = 4,
  parameter int VEC_W   = 4,
  parameter int ITR_W   = 2,
  parameter int CAUSE_W = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               glb_int_en,
  input logic [NQ-1:0]      q_event,
  input logic               ts_capture,
  input logic               ts_stat_clr,
  input logic [NQ:0]        pend_q,
  input logic               gnt_ts,
  input logic               irq_valid,
  input logic [VEC_W-1:0]   irq_vec,
  input logic [ITR_W-1:0]   irq_itr,
  input logic [CAUSE_W-1:0] cause_q,
  input logic               ts_status
);
  // R2: with global enable off and nothing held, queue events yield nothing
  p_drop_r2: assert property (@(posedge clk) disable iff (rst)
    (pend_q == '0 && !glb_int_en && !ts_capture) |=> !irq_valid);

  // R4: a vector-0 request always leaves the general event flag set
  p_vec0_evt_r4: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && irq_vec == '0) |-> cause_q[0]);

  // R5: no request without a held or arriving source
  p_no_spurious_r5: assert property (@(posedge clk) disable iff (rst)
    (pend_q == '0 && q_event == '0 && !ts_capture) |=> !irq_valid);

  // R6: capture always sets the status flag
  p_ts_status_r6: assert property (@(posedge clk) disable iff (rst)
    ts_capture |=> ts_status);

  // R7: a timestamp grant goes out on vector 0, throttle 0, with timesync cause
  p_ts_route_r7: assert property (@(posedge clk) disable iff (rst)
    gnt_ts |=> (irq_valid && irq_vec == '0 && irq_itr == '0 && cause_q[1]));

  // R8: clear without a concurrent capture empties the status flag
  p_ts_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (ts_stat_clr && !ts_capture) |=> !ts_status);
endmodule

bind irq_cause_router irq_cause_router_chk #(
  .NQ(NQ), .VEC_W(VEC_W), .ITR_W(ITR_W), .CAUSE_W(CAUSE_W)
) u_chk (
  .clk(clk), .rst(rst), .glb_int_en(glb_int_en), .q_event(q_event),
  .ts_capture(ts_capture), .ts_stat_clr(ts_stat_clr), .pend_q(pend_q),
  .gnt_ts(gnt_ts), .irq_valid(irq_valid), .irq_vec(irq_vec),
  .irq_itr(irq_itr), .cause_q(cause_q), .ts_status(ts_status)
);

// File: tb/irq_cause_router_test.sv
module irq_cause_router_test;
  localparam int CLK_PERIOD = 10;
  localparam int NQ = 4, VEC_W = 4, SLOT_W = 2, ITR_W = 2, CAUSE_W = 6;

  logic clk = 1'b0, rst = 1'b1, glb_int_en = 1'b0;
  logic [NQ-1:0] q_event = '0, q_cause_en = '0;
  logic [NQ*VEC_W-1:0] q_vec = '0;
  logic [NQ*SLOT_W-1:0] q_slot = '0;
  logic [NQ*ITR_W-1:0] q_itr = '0;
  logic ts_capture = 1'b0, ts_int_en = 1'b0, ts_cause_en = 1'b0, ts_stat_clr = 1'b0;
  logic [CAUSE_W-1:0] cause_clr = '0;
  logic irq_valid, ts_status;
  logic [VEC_W-1:0] irq_vec;
  logic [ITR_W-1:0] irq_itr;
  logic [CAUSE_W-1:0] cause_q;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [VEC_W+ITR_W-1:0] exp_q[$];
  string tag_q[$];
  logic [CAUSE_W-1:0] cause_exp = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_cause_router #(.NQ(NQ), .VEC_W(VEC_W), .SLOT_W(SLOT_W), .ITR_W(ITR_W)) uut (
    .clk(clk), .rst(rst), .glb_int_en(glb_int_en), .q_event(q_event),
    .q_cause_en(q_cause_en), .q_vec(q_vec), .q_slot(q_slot), .q_itr(q_itr),
    .ts_capture(ts_capture), .ts_int_en(ts_int_en), .ts_cause_en(ts_cause_en),
    .cause_clr(cause_clr), .ts_stat_clr(ts_stat_clr), .irq_valid(irq_valid),
    .irq_vec(irq_vec), .irq_itr(irq_itr), .cause_q(cause_q), .ts_status(ts_status));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(int q, bit en, int vec, int slot, int itr);
    q_cause_en[q] = en;
    q_vec[q*VEC_W +: VEC_W] = VEC_W'(vec);
    q_slot[q*SLOT_W +: SLOT_W] = SLOT_W'(slot);
    q_itr[q*ITR_W +: ITR_W] = ITR_W'(itr);
  endtask

  task automatic expect_irq(int vec, int itr, string tag);
    exp_q.push_back({VEC_W'(vec), ITR_W'(itr)});
    tag_q.push_back(tag);
  endtask

  task automatic pulse(logic [NQ-1:0] ev, bit ts);
    q_event = ev;
    ts_capture = ts;
    @(negedge clk);
    q_event = '0;
    ts_capture = 1'b0;
    cause_clr = '0;
    ts_stat_clr = 1'b0;
  endtask

  task automatic drain(string tag);
    repeat (4) @(negedge clk);
    chk({tag, " all expected requests issued"}, exp_q.size(), 0);
    chk({tag, " cause register"}, 32'(cause_q), 32'(cause_exp));
  endtask

  // monitor: every request must match the head of the scoreboard
  always @(negedge clk) begin
    if (!rst && irq_valid) begin
      if (exp_q.size() == 0) begin
        chk("R2/R5 unexpected request", {irq_vec, irq_itr}, 32'hDEAD);
      end else begin
        logic [VEC_W+ITR_W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {irq_vec, irq_itr}, e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq_valid", irq_valid, 0);
    chk("R1 cause_q", cause_q, 0);
    chk("R1 ts_status", ts_status, 0);

    glb_int_en = 1'b1;
    cfg(0, 1, 0, 0, 0);
    cfg(1, 1, 5, 0, 2);
    cfg(2, 1, 0, 3, 1);
    cfg(3, 1, 0, 1, 3);

    // R3 nonzero vector, no cause change
    expect_irq(5, 2, "R3 route q1");
    pulse(4'b0010, 0);
    drain("R4 nonzero vector");

    // R4 vector 0 with slot 3 -> bits 0 and 5
    expect_irq(0, 1, "R4 route q2");
    cause_exp = 6'b100001;
    pulse(4'b0100, 0);
    drain("R4 vector-0 cause");

    // R2 drops: global off, then cause enable off
    glb_int_en = 1'b0;
    pulse(4'b0001, 0);
    drain("R2 global off");
    glb_int_en = 1'b1;
    cfg(3, 0, 0, 1, 3);
    pulse(4'b1000, 0);
    drain("R2 cause enable off");
    cfg(3, 1, 0, 1, 3);

    // R5 simultaneous: q3,q1,q0 -> served q0, q1, q3
    cfg(1, 1, 7, 0, 2);
    expect_irq(0, 0, "R5 first q0");
    expect_irq(7, 2, "R5 second q1");
    expect_irq(0, 3, "R5 third q3");
    cause_exp = cause_exp | 6'b001101;
    pulse(4'b1011, 0);
    drain("R5 priority");

    // R9 merge: q0,q1 then q1 again while q1 still held
    expect_irq(0, 0, "R9 q0");
    expect_irq(7, 2, "R9 single q1");
    q_event = 4'b0011;
    @(negedge clk);
    pulse(4'b0010, 0);
    drain("R9 merge");

    // R8 clear all, then clear coinciding with set
    cause_clr = '1;
    pulse('0, 0);
    cause_exp = '0;
    drain("R8 clear all");
    cause_clr = 6'b100001;
    expect_irq(0, 1, "R8 q2 with clear");
    cause_exp = 6'b100001;
    pulse(4'b0100, 0);
    drain("R8 set beats clear");
    cause_clr = '1;
    pulse('0, 0);
    cause_exp = '0;

    // R6 capture with enables off: status only, no request
    pulse('0, 1);
    drain("R7 ts enables off");
    chk("R6 ts_status set", ts_status, 1);
    ts_stat_clr = 1'b1;
    pulse('0, 0);
    chk("R8 ts_status cleared", ts_status, 0);

    // R7 only one ts enable: no request
    ts_int_en = 1'b1;
    pulse('0, 1);
    drain("R7 one enable");

    // R7 both enables with a queue event in the same cycle
    ts_cause_en = 1'b1;
    expect_irq(7, 2, "R5 queue before ts");
    expect_irq(0, 0, "R7 ts request");
    cause_exp = 6'b000011;
    pulse(4'b0010, 1);
    drain("R7 ts and queue");
    chk("R6 ts_status after capture", ts_status, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule